// File: doc/BRIEF.md
# Floating-Point Store Execution Unit

This unit carries one floating-point store from instruction word to memory write. At issue it takes the 32-bit instruction word, the base value read from the integer register file and the value read from the floating-point register file. It returns the two register indices so the register files can be read in the same cycle. It then rebuilds the split 12-bit offset, adds it to the base to form the virtual address, and decides the access size. It also checks that the floating-point unit is switched on and that the address is aligned to the access size.

A store that passes these checks asks a translation port for a physical address. It then issues one byte-enabled write on a 64-bit memory port. The data sits in the byte lanes picked by the low address bits. When anything fails, one cause code and a trap value are presented with a one-cycle valid pulse, and no write goes out. The stored bits are never changed, and the number of cycles taken depends only on the handshakes, never on the data.

Top module: `fst_unit`

## Requirements
- R1: The offset is the sign extension of {instr[31:25], instr[11:7]} (bit 31 is the sign). The virtual address is base_val plus this offset, modulo 2^XLEN, and it is presented on xlat_vaddr.
- R2: rs1_idx equals instr[19:15] and fs2_idx equals instr[24:20], combinationally.
- R3: instr[14:12] selects the size: 3'b001 is 2 bytes, 3'b010 is 4 bytes, 3'b011 is 8 bytes. Any other value, including the byte code 3'b000, raises cause 2 with exc_tval 0. The same happens when instr[6:0] is not 7'b0100111.
- R4: An 8-byte store is legal only when FLEN is at least 64. With a narrower FLEN it raises cause 2.
- R5: When fp_enabled is low, an issued store raises cause 2 with exc_tval 0 and makes no translation request. This check ranks above the size check and the alignment check.
- R6: A virtual address that is not a multiple of the access size raises cause 6 with exc_tval equal to the virtual address. No translation request is made in that case.
- R7: A translation response with xlat_page_fault raises cause 15. One with only xlat_access_fault raises cause 7. Page fault wins when both are set. exc_tval carries the virtual address and no memory request is made.
- R8: A write acknowledged with mem_err raises cause 7 with exc_tval equal to the virtual address, and done stays low.
- R9: The write uses mem_addr = xlat_paddr with bits 2:0 cleared. mem_be has size-many ones shifted left by vaddr[2:0]. mem_wdata holds the low size bytes of fpr_val, unaltered (NaN payloads included) and shifted left by 8*vaddr[2:0], with zeros in every other lane.
- R10: When translation and memory answer in the cycle of their request, the timing is fixed. Issue-time exceptions pulse exc_valid after the issue edge. Translation faults pulse it one edge later. Completion (done) or a write error pulses two edges after issue. This holds for any stored data.
- R11: done and exc_valid are single-cycle pulses and never high together. mem_req is never high with exc_valid. issue_valid is ignored while a store is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | Start a store this cycle (taken only when idle) |
| instr | input | 32 | Store instruction word |
| fp_enabled | input | 1 | Floating-point unit enabled |
| rs1_idx | output | 5 | Base integer register index |
| fs2_idx | output | 5 | Source floating-point register index |
| base_val | input | XLEN | Base integer register value |
| fpr_val | input | FLEN | Source floating-point register value |
| xlat_req | output | 1 | Translation request, held until answered |
| xlat_vaddr | output | XLEN | Virtual address to translate |
| xlat_resp_valid | input | 1 | Translation answer valid |
| xlat_paddr | input | XLEN | Translated physical address |
| xlat_page_fault | input | 1 | Translation reported a page fault |
| xlat_access_fault | input | 1 | Translation reported an access fault |
| mem_req | output | 1 | Write request, held until acknowledged |
| mem_addr | output | XLEN | Doubleword-aligned physical address |
| mem_be | output | 8 | Byte enables |
| mem_wdata | output | 64 | Lane-aligned write data |
| mem_ack | input | 1 | Write acknowledged |
| mem_err | input | 1 | Write failed (with mem_ack) |
| done | output | 1 | Store retired (pulse) |
| exc_valid | output | 1 | Exception raised (pulse) |
| exc_cause | output | 5 | Exception cause code |
| exc_tval | output | XLEN | Trap value: virtual address, or 0 for cause 2 |

## Verification
The assertions assume the translation and memory stubs answer only while their request is high. They also assume mem_err is meaningful only with mem_ack, and that a fault flag counts only with its valid strobe. The bench's stubs echo each request straight back as its answer in the same cycle. The fault flags are constant for a whole scenario and are set between stores. issue_valid is driven one cycle at a time, and only once the previous store has finished, except in the one scenario that pokes it mid-flight on purpose.

// File: rtl/fst_pkg.sv
package fst_pkg;

    typedef enum logic [1:0] {
        FST_IDLE = 2'd0,
        FST_XLAT = 2'd1,
        FST_MEM  = 2'd2
    } fst_state_e;

    // log2 of access size in bytes
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam logic [1:0] SZ_DBL  = 2'd3;

    localparam logic [6:0] OPC_FP_STORE = 7'b0100111;

    localparam logic [4:0] CAUSE_ILLEGAL   = 5'd2;
    localparam logic [4:0] CAUSE_ST_ALIGN  = 5'd6;
    localparam logic [4:0] CAUSE_ST_ACCESS = 5'd7;
    localparam logic [4:0] CAUSE_ST_PAGE   = 5'd15;

    localparam int BUS_BYTES = 8;
    localparam int BUS_BITS  = BUS_BYTES * 8;

endpackage

// File: rtl/fst_decode.sv
module fst_decode
    import fst_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int FLEN = 64
) (
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] base_val,
    output logic [4:0]      rs1_idx,
    output logic [4:0]      fs2_idx,
    output logic [XLEN-1:0] vaddr,
    output logic [1:0]      size_lg,
    output logic            form_ok,
    output logic            misaligned
);
    localparam int  IMM_W  = 12;
    localparam bit  DBL_OK = (FLEN >= 64);

    logic [IMM_W-1:0] imm_split;
    logic [XLEN-1:0]  imm_sext;
    logic             size_ok;

    assign rs1_idx   = instr[19:15];
    assign fs2_idx   = instr[24:20];
    assign imm_split = {instr[31:25], instr[11:7]};
    assign imm_sext  = {{(XLEN-IMM_W){imm_split[IMM_W-1]}}, imm_split};
    assign vaddr     = base_val + imm_sext;

    always_comb begin
        size_lg = SZ_WORD;
        size_ok = 1'b0;
        case (instr[14:12])
            3'b001: begin size_lg = SZ_HALF; size_ok = 1'b1;   end
            3'b010: begin size_lg = SZ_WORD; size_ok = 1'b1;   end
            3'b011: begin size_lg = SZ_DBL;  size_ok = DBL_OK; end
            default: ;
        endcase
    end

    assign form_ok = size_ok && (instr[6:0] == OPC_FP_STORE);

    always_comb begin
        case (size_lg)
            SZ_HALF: misaligned = vaddr[0];
            SZ_WORD: misaligned = |vaddr[1:0];
            SZ_DBL:  misaligned = |vaddr[2:0];
            default: misaligned = 1'b0;
        endcase
    end

endmodule

// File: rtl/fst_lanes.sv
module fst_lanes
    import fst_pkg::*;
#(
    parameter int FLEN = 64
) (
    input  logic [FLEN-1:0]     fpr_val,
    input  logic [1:0]          size_lg,
    input  logic [2:0]          offset,
    output logic [BUS_BYTES-1:0] be,
    output logic [BUS_BITS-1:0]  wdata
);
    logic [BUS_BYTES-1:0] size_mask;
    logic [BUS_BITS-1:0]  lane_mask;
    logic [BUS_BITS-1:0]  src64;

    always_comb begin
        case (size_lg)
            SZ_HALF: size_mask = 8'h03;
            SZ_WORD: size_mask = 8'h0F;
            SZ_DBL:  size_mask = 8'hFF;
            default: size_mask = 8'h00;
        endcase
    end

    for (genvar b = 0; b < BUS_BYTES; b++) begin : g_lane
        assign lane_mask[b*8 +: 8] = {8{size_mask[b]}};
    end

    if (FLEN >= BUS_BITS) begin : g_wide
        assign src64 = fpr_val[BUS_BITS-1:0];
    end else begin : g_narrow
        assign src64 = {{(BUS_BITS-FLEN){1'b0}}, fpr_val};
    end

    assign be    = size_mask << offset;
    assign wdata = (src64 & lane_mask) << {offset, 3'b000};

endmodule

// File: rtl/fst_unit.sv
module fst_unit
    import fst_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int FLEN = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_valid,
    input  logic [31:0]          instr,
    input  logic                 fp_enabled,
    output logic [4:0]           rs1_idx,
    output logic [4:0]           fs2_idx,
    input  logic [XLEN-1:0]      base_val,
    input  logic [FLEN-1:0]      fpr_val,
    output logic                 xlat_req,
    output logic [XLEN-1:0]      xlat_vaddr,
    input  logic                 xlat_resp_valid,
    input  logic [XLEN-1:0]      xlat_paddr,
    input  logic                 xlat_page_fault,
    input  logic                 xlat_access_fault,
    output logic                 mem_req,
    output logic [XLEN-1:0]      mem_addr,
    output logic [BUS_BYTES-1:0] mem_be,
    output logic [BUS_BITS-1:0]  mem_wdata,
    input  logic                 mem_ack,
    input  logic                 mem_err,
    output logic                 done,
    output logic                 exc_valid,
    output logic [4:0]           exc_cause,
    output logic [XLEN-1:0]      exc_tval
);
    typedef struct packed {
        fst_state_e           state;
        logic [XLEN-1:0]      vaddr;
        logic [XLEN-1:0]      paddr;
        logic [BUS_BYTES-1:0] be;
        logic [BUS_BITS-1:0]  wdata;
        logic                 xlat_req;
        logic                 mem_req;
        logic                 done;
        logic                 exc;
        logic [4:0]           cause;
        logic [XLEN-1:0]      tval;
    } fst_regs_t;

    fst_regs_t r_d, r_q;

    logic [XLEN-1:0]      dec_vaddr;
    logic [1:0]           dec_size;
    logic                 dec_ok;
    logic                 dec_misaligned;
    logic [BUS_BYTES-1:0] lane_be;
    logic [BUS_BITS-1:0]  lane_wdata;
    logic                 idle_w;

    fst_decode #(.XLEN(XLEN), .FLEN(FLEN)) i_decode (
        .instr      (instr),
        .base_val   (base_val),
        .rs1_idx    (rs1_idx),
        .fs2_idx    (fs2_idx),
        .vaddr      (dec_vaddr),
        .size_lg    (dec_size),
        .form_ok    (dec_ok),
        .misaligned (dec_misaligned)
    );

    fst_lanes #(.FLEN(FLEN)) i_lanes (
        .fpr_val (fpr_val),
        .size_lg (dec_size),
        .offset  (dec_vaddr[2:0]),
        .be      (lane_be),
        .wdata   (lane_wdata)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.exc  = 1'b0;
        case (r_q.state)
            FST_IDLE: begin
                if (issue_valid) begin
                    if (!fp_enabled || !dec_ok) begin
                        r_d.exc   = 1'b1;
                        r_d.cause = CAUSE_ILLEGAL;
                        r_d.tval  = '0;
                    end else if (dec_misaligned) begin
                        r_d.exc   = 1'b1;
                        r_d.cause = CAUSE_ST_ALIGN;
                        r_d.tval  = dec_vaddr;
                    end else begin
                        r_d.state    = FST_XLAT;
                        r_d.vaddr    = dec_vaddr;
                        r_d.be       = lane_be;
                        r_d.wdata    = lane_wdata;
                        r_d.xlat_req = 1'b1;
                    end
                end
            end
            FST_XLAT: begin
                if (xlat_resp_valid) begin
                    r_d.xlat_req = 1'b0;
                    if (xlat_page_fault) begin
                        r_d.state = FST_IDLE;
                        r_d.exc   = 1'b1;
                        r_d.cause = CAUSE_ST_PAGE;
                        r_d.tval  = r_q.vaddr;
                    end else if (xlat_access_fault) begin
                        r_d.state = FST_IDLE;
                        r_d.exc   = 1'b1;
                        r_d.cause = CAUSE_ST_ACCESS;
                        r_d.tval  = r_q.vaddr;
                    end else begin
                        r_d.state   = FST_MEM;
                        r_d.paddr   = xlat_paddr & ~XLEN'(BUS_BYTES - 1);
                        r_d.mem_req = 1'b1;
                    end
                end
            end
            FST_MEM: begin
                if (mem_ack) begin
                    r_d.state   = FST_IDLE;
                    r_d.mem_req = 1'b0;
                    if (mem_err) begin
                        r_d.exc   = 1'b1;
                        r_d.cause = CAUSE_ST_ACCESS;
                        r_d.tval  = r_q.vaddr;
                    end else begin
                        r_d.done = 1'b1;
                    end
                end
            end
            default: r_d.state = FST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign idle_w     = (r_q.state == FST_IDLE);
    assign xlat_req   = r_q.xlat_req;
    assign xlat_vaddr = r_q.vaddr;
    assign mem_req    = r_q.mem_req;
    assign mem_addr   = r_q.paddr;
    assign mem_be     = r_q.be;
    assign mem_wdata  = r_q.wdata;
    assign done       = r_q.done;
    assign exc_valid  = r_q.exc;
    assign exc_cause  = r_q.cause;
    assign exc_tval   = r_q.tval;

endmodule

// File: rtl/fst_unit_chk.sv
module fst_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            issue_valid,
    input logic            fp_enabled,
    input logic            idle_w,
    input logic            xlat_req,
    input logic [XLEN-1:0] xlat_vaddr,
    input logic            xlat_resp_valid,
    input logic            xlat_page_fault,
    input logic            mem_req,
    input logic            mem_ack,
    input logic            mem_err,
    input logic [XLEN-1:0] mem_addr,
    input logic [7:0]      mem_be,
    input logic [63:0]     mem_wdata,
    input logic            done,
    input logic            exc_valid,
    input logic [4:0]      exc_cause
);
    a_r5_fp_off: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_w && issue_valid && !fp_enabled) |=> (exc_valid && exc_cause == 5'd2 && !xlat_req));

    a_r7_page_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_req && xlat_resp_valid && xlat_page_fault) |=> (exc_valid && exc_cause == 5'd15 && !mem_req));

    a_r7_xlat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_req && !xlat_resp_valid) |=> (xlat_req && $stable(xlat_vaddr)));

    a_r8_mem_error: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_err) |=> (exc_valid && exc_cause == 5'd7 && !done));

    a_r9_bus_shape: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_be != 8'h00 && mem_addr[2:0] == 3'b000));

    a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_be) && $stable(mem_wdata) && $stable(mem_addr)));

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_valid && (done || mem_req)));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !(xlat_req && mem_req));

endmodule

bind fst_unit fst_unit_chk #(.XLEN(XLEN)) i_fst_unit_chk (.*);

// File: tb/test_fst_unit.sv
`timescale 1ns/1ps
module test_fst_unit;
    localparam int XLEN = 64;
    localparam int FLEN = 64;
    localparam time CLK_HALF = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic issue_valid = 1'b0;
    logic [31:0] instr = '0;
    logic fp_enabled = 1'b1;
    logic [4:0] rs1_idx, fs2_idx;
    logic [XLEN-1:0] base_val = '0;
    logic [FLEN-1:0] fpr_val = '0;
    logic xlat_req, xlat_resp_valid;
    logic [XLEN-1:0] xlat_vaddr, xlat_paddr;
    logic pf_flag = 1'b0, af_flag = 1'b0, me_flag = 1'b0;
    logic mem_req, mem_ack;
    logic [XLEN-1:0] mem_addr;
    logic [7:0] mem_be;
    logic [63:0] mem_wdata;
    logic done, exc_valid;
    logic [4:0] exc_cause;
    logic [XLEN-1:0] exc_tval;

    localparam logic [XLEN-1:0] PA_BIAS = 64'h0000_0000_8000_0000;

    always #(CLK_HALF) clk = ~clk;

    assign xlat_resp_valid = xlat_req;
    assign xlat_paddr      = xlat_vaddr + PA_BIAS;
    assign mem_ack         = mem_req;

    fst_unit #(.XLEN(XLEN), .FLEN(FLEN)) i_fst_unit (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
        .fp_enabled(fp_enabled), .rs1_idx(rs1_idx), .fs2_idx(fs2_idx),
        .base_val(base_val), .fpr_val(fpr_val),
        .xlat_req(xlat_req), .xlat_vaddr(xlat_vaddr), .xlat_resp_valid(xlat_resp_valid),
        .xlat_paddr(xlat_paddr), .xlat_page_fault(pf_flag), .xlat_access_fault(af_flag),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_err(me_flag),
        .done(done), .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_tval(exc_tval)
    );

    // narrow-register instance for R4
    logic n_xreq, n_mreq, n_done, n_exc;
    logic [4:0] n_rs1, n_fs2, n_cause;
    logic [XLEN-1:0] n_vaddr, n_maddr, n_tval;
    logic [7:0] n_be;
    logic [63:0] n_wdata;

    fst_unit #(.XLEN(XLEN), .FLEN(32)) i_fst_unit_f32 (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
        .fp_enabled(fp_enabled), .rs1_idx(n_rs1), .fs2_idx(n_fs2),
        .base_val(base_val), .fpr_val(fpr_val[31:0]),
        .xlat_req(n_xreq), .xlat_vaddr(n_vaddr), .xlat_resp_valid(n_xreq),
        .xlat_paddr(n_vaddr), .xlat_page_fault(1'b0), .xlat_access_fault(1'b0),
        .mem_req(n_mreq), .mem_addr(n_maddr), .mem_be(n_be), .mem_wdata(n_wdata),
        .mem_ack(n_mreq), .mem_err(1'b0),
        .done(n_done), .exc_valid(n_exc), .exc_cause(n_cause), .exc_tval(n_tval)
    );

    int checks = 0;
    int errors = 0;

    // captured results of the last store
    int g_lat, g_xlat_cycles, g_mem_cycles;
    logic g_done, g_exc;
    logic [4:0] g_cause;
    logic [XLEN-1:0] g_tval, g_vaddr_seen, g_addr;
    logic [7:0] g_be;
    logic [63:0] g_wdata;
    logic n_exc1, n_xreq1;
    logic [4:0] n_cause1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [11:0] imm, input logic [4:0] fs2,
                                       input logic [4:0] rs1, input logic [2:0] f3);
        return {imm[11:5], fs2, rs1, f3, imm[4:0], 7'b0100111};
    endfunction

    function automatic logic [63:0] sx(input logic [11:0] imm);
        return {{52{imm[11]}}, imm};
    endfunction

    task automatic run_op(input logic [31:0] ins, input logic [63:0] base,
                          input logic [63:0] fpr, input logic en,
                          input logic pf, input logic af, input logic me,
                          input bit poke);
        pf_flag = pf; af_flag = af; me_flag = me;
        fp_enabled = en;
        @(negedge clk);
        instr = ins; base_val = base; fpr_val = fpr; issue_valid = 1'b1;
        g_lat = 0; g_xlat_cycles = 0; g_mem_cycles = 0;
        g_done = 0; g_exc = 0; g_cause = '0; g_tval = '0;
        g_addr = '0; g_be = '0; g_wdata = '0; g_vaddr_seen = '0;
        @(negedge clk);
        issue_valid = 1'b0;
        for (int c = 1; c <= 20; c++) begin
            if (c > 1) @(negedge clk);
            if (c == 1) begin
                n_exc1 = n_exc; n_xreq1 = n_xreq; n_cause1 = n_cause;
                if (poke) begin
                    instr = mk(12'h000, 5'd0, 5'd0, 3'b000);
                    issue_valid = 1'b1;
                end
            end else if (poke) begin
                issue_valid = 1'b0;
            end
            if (xlat_req) begin g_xlat_cycles++; g_vaddr_seen = xlat_vaddr; end
            if (mem_req) begin
                g_mem_cycles++; g_addr = mem_addr; g_be = mem_be; g_wdata = mem_wdata;
            end
            if (done || exc_valid) begin
                g_lat = c; g_done = done; g_exc = exc_valid;
                g_cause = exc_cause; g_tval = exc_tval;
                break;
            end
        end
        issue_valid = 1'b0;
        if (g_lat == 0) chk(0, "R10", "no completion", 64'd0, 64'd1);
        @(negedge clk);
        chk(!done && !exc_valid && !xlat_req && !mem_req, "R11", "quiet after end",
            {done, exc_valid, xlat_req, mem_req}, 64'd0);
    endtask

    task automatic expect_ok(input string req, input logic [63:0] vaddr,
                             input logic [7:0] be, input logic [63:0] wd);
        chk(g_done && !g_exc, req, "retired", {g_done, g_exc}, 64'd2);
        chk(g_lat == 3, "R10", "success latency", g_lat, 64'd3);
        chk(g_vaddr_seen == vaddr, "R1", "vaddr", g_vaddr_seen, vaddr);
        chk(g_mem_cycles == 1, req, "one write", g_mem_cycles, 64'd1);
        chk(g_addr == ((vaddr + PA_BIAS) & ~64'd7), "R9", "mem_addr", g_addr,
            (vaddr + PA_BIAS) & ~64'd7);
        chk(g_be == be, "R9", "mem_be", g_be, be);
        chk(g_wdata == wd, "R9", "mem_wdata", g_wdata, wd);
    endtask

    task automatic expect_exc(input string req, input logic [4:0] cause,
                              input logic [63:0] tval, input int lat,
                              input int xl, input int mm);
        chk(g_exc && !g_done, req, "exception raised", {g_exc, g_done}, 64'd2);
        chk(g_cause == cause, req, "cause", g_cause, cause);
        chk(g_tval == tval, req, "tval", g_tval, tval);
        chk(g_lat == lat, "R10", "exception latency", g_lat, lat);
        chk(g_xlat_cycles == xl, req, "translation cycles", g_xlat_cycles, xl);
        chk(g_mem_cycles == mm, req, "write cycles", g_mem_cycles, mm);
    endtask

    task automatic t_reset();
        chk(!done && !exc_valid && !xlat_req && !mem_req, "R11", "reset outputs",
            {done, exc_valid, xlat_req, mem_req}, 64'd0);
    endtask

    task automatic t_indices();
        @(negedge clk);
        instr = mk(12'h5A5, 5'd19, 5'd11, 3'b010);
        #1;
        chk(rs1_idx == 5'd11, "R2", "rs1_idx", rs1_idx, 64'd11);
        chk(fs2_idx == 5'd19, "R2", "fs2_idx", fs2_idx, 64'd19);
    endtask

    task automatic t_word_pos();
        logic [63:0] va = 64'h1000 + 64'h14;
        run_op(mk(12'h014, 5'd3, 5'd4, 3'b010), 64'h1000, 64'hDEAD_BEEF_1234_5678,
               1, 0, 0, 0, 0);
        expect_ok("R9", va, 8'hF0, 64'h1234_5678_0000_0000);
    endtask

    task automatic t_half_neg();
        logic [63:0] va = 64'h2000 + sx(12'hF86);
        run_op(mk(12'hF86, 5'd1, 5'd2, 3'b001), 64'h2000, 64'h1111_2222_3333_ABCD,
               1, 0, 0, 0, 0);
        expect_ok("R1", va, 8'hC0, 64'hABCD_0000_0000_0000);
    endtask

    task automatic t_nan_payloads();
        run_op(mk(12'h008, 5'd7, 5'd8, 3'b011), 64'h3000, 64'h7FF0_0000_0000_0001,
               1, 0, 0, 0, 0);
        expect_ok("R9", 64'h3008, 8'hFF, 64'h7FF0_0000_0000_0001);
        chk(g_lat == 3, "R10", "latency data A", g_lat, 64'd3);
        run_op(mk(12'h008, 5'd7, 5'd8, 3'b011), 64'h3000, 64'h0000_0000_0000_0000,
               1, 0, 0, 0, 0);
        chk(g_lat == 3, "R10", "latency data B", g_lat, 64'd3);
        run_op(mk(12'h000, 5'd7, 5'd8, 3'b010), 64'h3010, 64'h1234_0000_7F80_0001,
               1, 0, 0, 0, 0);
        expect_ok("R9", 64'h3010, 8'h0F, 64'h0000_0000_7F80_0001);
    endtask

    task automatic t_bad_width();
        run_op(mk(12'h000, 5'd1, 5'd1, 3'b000), 64'h4000, 64'h55, 1, 0, 0, 0, 0);
        expect_exc("R3", 5'd2, 64'd0, 1, 0, 0);
        run_op(mk(12'h000, 5'd1, 5'd1, 3'b100), 64'h4000, 64'h55, 1, 0, 0, 0, 0);
        expect_exc("R3", 5'd2, 64'd0, 1, 0, 0);
        run_op({mk(12'h000, 5'd1, 5'd1, 3'b010)} ^ 32'h0000_0040, 64'h4000, 64'h55,
               1, 0, 0, 0, 0);
        expect_exc("R3", 5'd2, 64'd0, 1, 0, 0);
    endtask

    task automatic t_fp_off();
        run_op(mk(12'h001, 5'd1, 5'd1, 3'b010), 64'h4000, 64'h55, 0, 0, 0, 0, 0);
        expect_exc("R5", 5'd2, 64'd0, 1, 0, 0);
    endtask

    task automatic t_misaligned();
        run_op(mk(12'h002, 5'd1, 5'd1, 3'b010), 64'h5000, 64'h55, 1, 0, 0, 0, 0);
        expect_exc("R6", 5'd6, 64'h5002, 1, 0, 0);
        run_op(mk(12'h004, 5'd1, 5'd1, 3'b011), 64'h5000, 64'h55, 1, 0, 0, 0, 0);
        expect_exc("R6", 5'd6, 64'h5004, 1, 0, 0);
        run_op(mk(12'hFFF, 5'd1, 5'd1, 3'b001), 64'h5000, 64'h55, 1, 0, 0, 0, 0);
        expect_exc("R6", 5'd6, 64'h4FFF, 1, 0, 0);
    endtask

    task automatic t_xlat_faults();
        run_op(mk(12'h010, 5'd1, 5'd1, 3'b010), 64'h6000, 64'h55, 1, 1, 0, 0, 0);
        expect_exc("R7", 5'd15, 64'h6010, 2, 1, 0);
        run_op(mk(12'h010, 5'd1, 5'd1, 3'b010), 64'h6000, 64'h55, 1, 1, 1, 0, 0);
        expect_exc("R7", 5'd15, 64'h6010, 2, 1, 0);
        run_op(mk(12'h018, 5'd1, 5'd1, 3'b011), 64'h6000, 64'h55, 1, 0, 1, 0, 0);
        expect_exc("R7", 5'd7, 64'h6018, 2, 1, 0);
    endtask

    task automatic t_mem_err();
        run_op(mk(12'h020, 5'd1, 5'd1, 3'b001), 64'h7000, 64'h55, 1, 0, 0, 1, 0);
        expect_exc("R8", 5'd7, 64'h7020, 3, 1, 1);
    endtask

    task automatic t_busy_ignore();
        run_op(mk(12'h00C, 5'd1, 5'd1, 3'b010), 64'h8000, 64'hCAFE_F00D, 1, 0, 0, 0, 1);
        expect_ok("R11", 64'h800C, 8'hF0, 64'hCAFE_F00D_0000_0000);
    endtask

    task automatic t_narrow_flen();
        run_op(mk(12'h000, 5'd1, 5'd1, 3'b011), 64'h9000, 64'h0123_4567_89AB_CDEF,
               1, 0, 0, 0, 0);
        chk(n_exc1 && n_cause1 == 5'd2, "R4", "double on 32-bit FLEN illegal",
            {n_exc1, n_cause1}, {1'b1, 5'd2});
        chk(g_done, "R4", "double on 64-bit FLEN retires", g_done, 64'd1);
        run_op(mk(12'h004, 5'd1, 5'd1, 3'b010), 64'h9000, 64'h0123_4567_89AB_CDEF,
               1, 0, 0, 0, 0);
        chk(!n_exc1 && n_xreq1, "R4", "word on 32-bit FLEN proceeds",
            {n_exc1, n_xreq1}, 64'd1);
    endtask

    initial begin
        #(CLK_HALF * 2 * 200000);
        chk(0, "R10", "watchdog expired", 64'd0, 64'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_indices();
        t_word_pos();
        t_half_neg();
        t_nan_payloads();
        t_bad_width();
        t_fp_off();
        t_misaligned();
        t_xlat_faults();
        t_mem_err();
        t_busy_ignore();
        t_narrow_flen();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule